// File: doc/BRIEF.md
# Coalescing Write Buffer for a Write-Through Cache

The block sits between a write-through cache and the memory system. Processor stores are accepted into a small queue of block-sized entries, so the processor moves on while memory finishes the writes. Each entry holds one aligned block of several words, with one valid bit per word. A store to a block that already has an open entry goes into that entry, so several stores to the same block reach memory as a single masked transaction.

Entries leave for memory oldest first, one per handshake. The entry at the memory port is frozen. A store to its block starts a new entry. Before a read miss goes to memory, the miss logic presents the word address to the lookup port. The block then does one of three things:
- If a buffered copy of that word exists, it returns the youngest copy.
- If an entry covers the block but not that word, it asks the read to wait until those entries have drained.
- If nothing in the buffer covers the block, the read goes ahead at once.

Addresses are word addresses. The low `$clog2(WORDS)` bits select the word within a block, and the remaining bits form the block number. `DEPTH` and `WORDS` must be powers of two.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid_o`=0, `wr_ready_o`=1, `rd_hit_o`=0 and `rd_wait_o`=0.
- R2: A store is taken when `wr_valid_i` and `wr_ready_o` are both high. Into an empty buffer it appears at the memory port on the next cycle with these fields:
  - `mem_blk_o` = `wr_addr_i[ADDR_W-1:2]`.
  - Word k (k = `wr_addr_i[1:0]`) is placed at `mem_data_o[32k+31:32k]`.
  - `mem_mask_o` has only bit k set.
  - Words never written read as zero.
- R3: A store whose block matches a buffered entry other than the one at the memory port is merged into that entry. The store sets that word's mask bit and replaces that word's data. No new entry is used.
- R4: While `mem_valid_o`=1 and `mem_ready_i`=0, `mem_blk_o`, `mem_data_o` and `mem_mask_o` hold steady. A store to the block shown at the memory port opens a new entry.
- R5: Entries are presented in the order they were opened, one per cycle with `mem_valid_o` and `mem_ready_i` both high. The next entry is shown in the following cycle.
- R6: With `DEPTH` entries in use, `wr_ready_o` is low for a store that cannot merge under R3. It stays high for one that can. A drain in the same cycle does not raise `wr_ready_o`.
- R7: With `rd_req_i` high, if any buffered entry holds the addressed word valid, `rd_hit_o` is 1. In that case `rd_data_o` is the copy from the most recently opened such entry.
- R8: With `rd_req_i` high, `rd_wait_o` is 1 when an entry covers the block but none holds the addressed word. It falls once those entries have drained.
- R9: With no entry covering the block, or with `rd_req_i` low, `rd_hit_o` and `rd_wait_o` are both 0. The lookup sees only stores taken in earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Processor store request |
| wr_ready_o | output | 1 | Store can be taken this cycle |
| wr_addr_i | input | ADDR_W | Store word address |
| wr_data_i | input | DATA_W | Store data |
| rd_req_i | input | 1 | Read-miss lookup request |
| rd_addr_i | input | ADDR_W | Read-miss word address |
| rd_hit_o | output | 1 | Word forwarded from the buffer |
| rd_data_o | output | DATA_W | Forwarded word |
| rd_wait_o | output | 1 | Block is buffered without this word; hold the read |
| mem_valid_o | output | 1 | Oldest entry offered to memory |
| mem_ready_i | input | 1 | Memory takes the offered entry |
| mem_blk_o | output | ADDR_W-log2(WORDS) | Block number of the offered entry |
| mem_data_o | output | WORDS*DATA_W | Block data of the offered entry |
| mem_mask_o | output | WORDS | Word-valid mask of the offered entry |

## Verification
The assertions assume the following about the environment:
- `wr_valid_i` and its address and data are stable at the clock edge.
- Memory may hold `mem_ready_i` low for any length of time.
- A read that sees `rd_wait_o` waits rather than going to memory.

The stimulus changes inputs only on the falling edge. It keeps `mem_ready_i` mostly low so that the buffer fills and merges happen often. It draws store and read addresses from a handful of blocks so that merges, same-block new entries and partial-block waits occur often. The bench keeps a model of the entry queue, built from the requirements, and compares every output against it in every cycle. A final read sweep covers every word of every block in use against a frozen full buffer.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [1:0] {
    LK_CLEAR = 2'd0,
    LK_FWD   = 2'd1,
    LK_WAIT  = 2'd2
  } lk_e;
endpackage

// File: rtl/wbuf_cmp.sv
module wbuf_cmp #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 14
) (
  input  logic [DEPTH-1:0]       occ_i,
  input  logic [DEPTH*BLK_W-1:0] blk_i,
  input  logic [BLK_W-1:0]       key_i,
  output logic [DEPTH-1:0]       hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = occ_i[i] && (blk_i[i*BLK_W +: BLK_W] == key_i);
  end
endmodule

// File: rtl/wbuf_pick.sv
// Picks the youngest requesting slot of a circular queue whose oldest slot is head_i.
module wbuf_pick #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic [DEPTH-1:0] req_i,
  input  logic [PTR_W-1:0] head_i,
  output logic             found_o,
  output logic [PTR_W-1:0] idx_o
);
  logic [PTR_W-1:0] slot;

  always_comb begin
    found_o = 1'b0;
    idx_o   = head_i;
    slot    = head_i;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head_i + PTR_W'(k);
      if (req_i[slot]) begin
        found_o = 1'b1;
        idx_o   = slot;
      end
    end
  end
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int BLK_W  = 14,
  parameter int OFS_W  = 2,
  parameter int PTR_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_fire_i,
  input  logic                          merge_i,
  input  logic [PTR_W-1:0]              merge_idx_i,
  input  logic [BLK_W-1:0]              wr_blk_i,
  input  logic [OFS_W-1:0]              wr_ofs_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          pop_i,
  output logic [DEPTH-1:0]              occ_o,
  output logic [DEPTH*BLK_W-1:0]        blk_o,
  output logic [DEPTH*WORDS*DATA_W-1:0] data_o,
  output logic [DEPTH*WORDS-1:0]        mask_o,
  output logic [PTR_W-1:0]              head_o,
  output logic [CNT_W-1:0]              count_o
);
  localparam int LINE_W = WORDS * DATA_W;

  logic [BLK_W-1:0]  blk_q  [DEPTH];
  logic [LINE_W-1:0] data_q [DEPTH];
  logic [WORDS-1:0]  mask_q [DEPTH];
  logic [DEPTH-1:0]  occ_q;
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;

  logic [LINE_W-1:0] new_line;
  logic [WORDS-1:0]  new_mask;
  logic              alloc;

  assign alloc = wr_fire_i && !merge_i;

  always_comb begin
    new_line = '0;
    new_line[int'(wr_ofs_i)*DATA_W +: DATA_W] = wr_data_i;
    new_mask = '0;
    new_mask[wr_ofs_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        blk_q[i]  <= '0;
        data_q[i] <= '0;
        mask_q[i] <= '0;
      end
      occ_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (wr_fire_i && merge_i) begin
        data_q[merge_idx_i][int'(wr_ofs_i)*DATA_W +: DATA_W] <= wr_data_i;
        mask_q[merge_idx_i][wr_ofs_i] <= 1'b1;
      end
      if (alloc) begin
        blk_q[tail_q]  <= wr_blk_i;
        data_q[tail_q] <= new_line;
        mask_q[tail_q] <= new_mask;
        occ_q[tail_q]  <= 1'b1;
        tail_q         <= tail_q + 1'b1;
      end
      if (pop_i) begin
        occ_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      count_q <= count_q + CNT_W'(alloc) - CNT_W'(pop_i);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign blk_o[i*BLK_W +: BLK_W]    = blk_q[i];
    assign data_o[i*LINE_W +: LINE_W] = data_q[i];
    assign mask_o[i*WORDS +: WORDS]   = mask_q[i];

    assert_live_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      occ_q[i] |-> (mask_q[i] != '0));
  end

  assign occ_o   = occ_q;
  assign head_o  = head_q;
  assign count_o = count_q;

  assert_occ_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(occ_q) == int'(count_q));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_q) <= DEPTH);
endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2,
  parameter int PTR_W  = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic [DEPTH-1:0]              blk_hit_i,
  input  logic [DEPTH*WORDS-1:0]        mask_i,
  input  logic [DEPTH*WORDS*DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]              head_i,
  input  logic [OFS_W-1:0]              ofs_i,
  output logic                          hit_o,
  output logic                          wait_o,
  output logic [DATA_W-1:0]             data_o
);
  logic [DEPTH-1:0] word_hit;
  logic             found;
  logic [PTR_W-1:0] idx;
  lk_e              st;

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign word_hit[i] = blk_hit_i[i] && mask_i[i*WORDS + int'(ofs_i)];
  end

  wbuf_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_pick (
    .req_i   (word_hit),
    .head_i  (head_i),
    .found_o (found),
    .idx_o   (idx)
  );

  always_comb begin
    if (!req_i)          st = LK_CLEAR;
    else if (found)      st = LK_FWD;
    else if (|blk_hit_i) st = LK_WAIT;
    else                 st = LK_CLEAR;
  end

  assign hit_o  = (st == LK_FWD);
  assign wait_o = (st == LK_WAIT);
  assign data_o = hit_o ? data_i[(int'(idx)*WORDS + int'(ofs_i))*DATA_W +: DATA_W] : '0;

  assert_fwd_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_o, wait_o}));
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(hit_o || wait_o));
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_valid_i,
  output logic                                wr_ready_o,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  input  logic                                rd_req_i,
  input  logic [ADDR_W-1:0]                   rd_addr_i,
  output logic                                rd_hit_o,
  output logic [DATA_W-1:0]                   rd_data_o,
  output logic                                rd_wait_o,
  output logic                                mem_valid_o,
  input  logic                                mem_ready_i,
  output logic [ADDR_W-$clog2(WORDS)-1:0]     mem_blk_o,
  output logic [WORDS*DATA_W-1:0]             mem_data_o,
  output logic [WORDS-1:0]                    mem_mask_o
);
  localparam int OFS_W  = $clog2(WORDS);
  localparam int BLK_W  = ADDR_W - OFS_W;
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LINE_W = WORDS * DATA_W;

  logic [DEPTH-1:0]              occ;
  logic [DEPTH*BLK_W-1:0]        blk_flat;
  logic [DEPTH*LINE_W-1:0]       data_flat;
  logic [DEPTH*WORDS-1:0]        mask_flat;
  logic [PTR_W-1:0]              head;
  logic [CNT_W-1:0]              count;

  logic [BLK_W-1:0] wr_blk, rd_blk;
  logic [OFS_W-1:0] wr_ofs, rd_ofs;
  logic [DEPTH-1:0] w_hit, r_hit;
  logic             w_found, merge, full, wr_fire, pop;
  logic [PTR_W-1:0] w_idx;

  assign wr_blk = wr_addr_i[ADDR_W-1:OFS_W];
  assign wr_ofs = wr_addr_i[OFS_W-1:0];
  assign rd_blk = rd_addr_i[ADDR_W-1:OFS_W];
  assign rd_ofs = rd_addr_i[OFS_W-1:0];

  wbuf_cmp #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_wcmp (
    .occ_i (occ), .blk_i (blk_flat), .key_i (wr_blk), .hit_o (w_hit)
  );

  wbuf_cmp #(.DEPTH(DEPTH), .BLK_W(BLK_W)) u_rcmp (
    .occ_i (occ), .blk_i (blk_flat), .key_i (rd_blk), .hit_o (r_hit)
  );

  // youngest entry of the block; the one at the memory port is frozen
  wbuf_pick #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wpick (
    .req_i (w_hit), .head_i (head), .found_o (w_found), .idx_o (w_idx)
  );

  assign merge      = w_found && (w_idx != head);
  assign full       = (count == CNT_W'(DEPTH));
  assign wr_ready_o = merge || !full;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign mem_valid_o = (count != '0);
  assign pop        = mem_valid_o && mem_ready_i;

  wbuf_store #(
    .DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W),
    .OFS_W(OFS_W), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_fire_i   (wr_fire),
    .merge_i     (merge),
    .merge_idx_i (w_idx),
    .wr_blk_i    (wr_blk),
    .wr_ofs_i    (wr_ofs),
    .wr_data_i   (wr_data_i),
    .pop_i       (pop),
    .occ_o       (occ),
    .blk_o       (blk_flat),
    .data_o      (data_flat),
    .mask_o      (mask_flat),
    .head_o      (head),
    .count_o     (count)
  );

  wbuf_fwd #(
    .DEPTH(DEPTH), .WORDS(WORDS), .DATA_W(DATA_W), .OFS_W(OFS_W), .PTR_W(PTR_W)
  ) u_fwd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (rd_req_i),
    .blk_hit_i (r_hit),
    .mask_i    (mask_flat),
    .data_i    (data_flat),
    .head_i    (head),
    .ofs_i     (rd_ofs),
    .hit_o     (rd_hit_o),
    .wait_o    (rd_wait_o),
    .data_o    (rd_data_o)
  );

  assign mem_blk_o  = blk_flat[int'(head)*BLK_W +: BLK_W];
  assign mem_data_o = data_flat[int'(head)*LINE_W +: LINE_W];
  assign mem_mask_o = mask_flat[int'(head)*WORDS +: WORDS];

  assert_stall_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o) |-> (int'(count) == DEPTH));
  assert_head_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_blk_o) && $stable(mem_data_o) && $stable(mem_mask_o)));
  assert_merge_no_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && merge) |=> (count == $past(count) - CNT_W'($past(pop))));
  assert_take_shows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> mem_valid_o);
endmodule

// File: tb/sim_merge_wbuf.sv
`timescale 1ns/1ps
module sim_merge_wbuf;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int DEPTH  = 4;
  localparam int BLK_W  = ADDR_W - 2;
  localparam int LINE_W = WORDS * DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, mem_ready = 1'b0, rd_req = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, rd_hit, rd_wait, mem_valid;
  logic [DATA_W-1:0] rd_data;
  logic [BLK_W-1:0] mem_blk;
  logic [LINE_W-1:0] mem_data;
  logic [WORDS-1:0] mem_mask;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lcg = 32'h1234_5678;

  // model: index 0 is the entry at the memory port
  int               mcnt = 0;
  logic [BLK_W-1:0]  mblk [DEPTH];
  logic [LINE_W-1:0] mdat [DEPTH];
  logic [WORDS-1:0]  mmsk [DEPTH];

  always #10 clk = ~clk;

  merge_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH)) u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .wr_valid_i (wr_valid), .wr_ready_o (wr_ready), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
    .rd_req_i (rd_req), .rd_addr_i (rd_addr), .rd_hit_o (rd_hit), .rd_data_o (rd_data),
    .rd_wait_o (rd_wait),
    .mem_valid_o (mem_valid), .mem_ready_i (mem_ready), .mem_blk_o (mem_blk),
    .mem_data_o (mem_data), .mem_mask_o (mem_mask)
  );

  task automatic chk(input string tag, input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  task automatic step(input logic wv, input logic [ADDR_W-1:0] wa, input logic [DATA_W-1:0] wd,
                      input logic mr, input logic rq, input logic [ADDR_W-1:0] ra);
    int mj;
    int fj;
    logic merge, bh, e_rdy, e_hit, e_wait;
    logic [DATA_W-1:0] e_dat;
    @(negedge clk);
    wr_valid = wv; wr_addr = wa; wr_data = wd; mem_ready = mr; rd_req = rq; rd_addr = ra;
    #2;
    mj = -1;
    for (int j = 0; j < mcnt; j++) if (mblk[j] == wa[ADDR_W-1:2]) mj = j;
    merge = (mj > 0);
    e_rdy = merge || (mcnt < DEPTH);
    chk("R6 wr_ready", LINE_W'(wr_ready), LINE_W'(e_rdy));
    chk("R5 mem_valid", LINE_W'(mem_valid), LINE_W'(mcnt > 0));
    if (mcnt > 0) begin
      chk("R5 mem_blk", LINE_W'(mem_blk), LINE_W'(mblk[0]));
      chk("R3 mem_data", mem_data, mdat[0]);
      chk("R3 mem_mask", LINE_W'(mem_mask), LINE_W'(mmsk[0]));
    end
    bh = 1'b0; fj = -1;
    for (int j = 0; j < mcnt; j++) if (mblk[j] == ra[ADDR_W-1:2]) begin
      bh = 1'b1;
      if (mmsk[j][ra[1:0]]) fj = j;
    end
    e_hit  = rq && (fj >= 0);
    e_wait = rq && bh && (fj < 0);
    e_dat  = e_hit ? mdat[fj][int'(ra[1:0])*DATA_W +: DATA_W] : '0;
    chk("R7 rd_hit", LINE_W'(rd_hit), LINE_W'(e_hit));
    if (e_hit) chk("R7 rd_data", LINE_W'(rd_data), LINE_W'(e_dat));
    chk("R8 rd_wait", LINE_W'(rd_wait), LINE_W'(e_wait));
    // model next state
    if (wv && e_rdy) begin
      if (merge) begin
        mdat[mj][int'(wa[1:0])*DATA_W +: DATA_W] = wd;
        mmsk[mj][wa[1:0]] = 1'b1;
      end else begin
        mblk[mcnt] = wa[ADDR_W-1:2];
        mdat[mcnt] = '0;
        mdat[mcnt][int'(wa[1:0])*DATA_W +: DATA_W] = wd;
        mmsk[mcnt] = '0;
        mmsk[mcnt][wa[1:0]] = 1'b1;
        mcnt++;
      end
    end
    if (mr && mcnt > 0) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        mblk[j] = mblk[j+1]; mdat[j] = mdat[j+1]; mmsk[j] = mmsk[j+1];
      end
      mcnt--;
    end
  endtask

  function automatic logic [ADDR_W-1:0] wa_of(input int blk, input int ofs);
    return ADDR_W'(blk * 4 + ofs);
  endfunction

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int j = 0; j < DEPTH; j++) begin mblk[j] = '0; mdat[j] = '0; mmsk[j] = '0; end
    #45 rst_n = 1'b1;
    // R1 reset state
    step(0, '0, '0, 0, 1, wa_of(0, 0));
    chk("R1 mem_valid", LINE_W'(mem_valid), '0);
    chk("R1 wr_ready", LINE_W'(wr_ready), LINE_W'(1));
    chk("R1 rd_hit", LINE_W'(rd_hit), '0);
    chk("R1 rd_wait", LINE_W'(rd_wait), '0);

    // R2 first store shows at memory port
    step(1, wa_of(5, 2), 32'hA0A0_0002, 0, 0, '0);
    step(0, '0, '0, 0, 1, wa_of(5, 2));
    chk("R2 mem_valid", LINE_W'(mem_valid), LINE_W'(1));
    chk("R2 mem_blk", LINE_W'(mem_blk), LINE_W'(5));
    chk("R2 mem_mask", LINE_W'(mem_mask), LINE_W'(4'b0100));
    chk("R2 mem_data", mem_data, {32'h0, 32'hA0A0_0002, 64'h0});
    chk("R7 fwd", LINE_W'(rd_data), LINE_W'(32'hA0A0_0002));

    // R4 store to frozen block opens new entry, R3 next store merges
    step(1, wa_of(5, 1), 32'hB1, 0, 0, '0);
    step(1, wa_of(5, 3), 32'hB3, 0, 0, '0);
    step(0, '0, '0, 0, 1, wa_of(5, 1));
    chk("R4 head mask held", LINE_W'(mem_mask), LINE_W'(4'b0100));
    chk("R7 fwd young", LINE_W'(rd_data), LINE_W'(32'hB1));
    step(0, '0, '0, 0, 1, wa_of(5, 0));
    chk("R8 wait", LINE_W'(rd_wait), LINE_W'(1));
    step(0, '0, '0, 1, 0, '0);
    step(0, '0, '0, 0, 1, wa_of(5, 0));
    chk("R3 merged mask", LINE_W'(mem_mask), LINE_W'(4'b1010));
    chk("R3 merged data", mem_data, {32'hB3, 32'h0, 32'hB1, 32'h0});
    chk("R8 wait held", LINE_W'(rd_wait), LINE_W'(1));
    step(0, '0, '0, 1, 0, '0);
    step(0, '0, '0, 0, 1, wa_of(5, 0));
    chk("R8 wait clears", LINE_W'(rd_wait), '0);
    chk("R9 clear hit", LINE_W'(rd_hit), '0);
    chk("R5 empty", LINE_W'(mem_valid), '0);

    // R9 same-cycle store not visible
    step(1, wa_of(20, 0), 32'hC0, 0, 1, wa_of(20, 0));
    chk("R9 same cycle", LINE_W'(rd_hit | rd_wait), '0);
    step(0, '0, '0, 1, 0, '0);

    // R6 full buffer
    for (int b = 10; b < 14; b++) step(1, wa_of(b, 0), 32'(b), 0, 0, '0);
    step(1, wa_of(14, 0), 32'hE0, 0, 0, '0);
    chk("R6 full stall", LINE_W'(wr_ready), '0);
    step(1, wa_of(12, 2), 32'hE2, 0, 0, '0);
    chk("R6 merge when full", LINE_W'(wr_ready), LINE_W'(1));
    step(1, wa_of(10, 1), 32'hE1, 1, 0, '0);
    chk("R6 head block full", LINE_W'(wr_ready), '0);
    for (int b = 0; b < 6; b++) step(0, '0, '0, 1, 0, '0);

    // mixed traffic over few blocks
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = rnd();
      step(r[0] | r[1], wa_of(int'(r[4:2] % 3'd5), int'(r[6:5])), rnd(),
           (r[9:8] == 2'b00), r[10], wa_of(int'(r[14:12] % 3'd5), int'(r[16:15])));
    end

    // read sweep against a frozen full buffer
    for (int n = 0; n < 12; n++) begin
      logic [31:0] r;
      r = rnd();
      step(1, wa_of(int'(r[3:0] % 4'd6), int'(r[5:4])), rnd(), 0, 0, '0);
    end
    for (int b = 0; b < 6; b++)
      for (int o = 0; o < 4; o++) step(0, '0, '0, 0, 1, wa_of(b, o));
    for (int n = 0; n < 8; n++) step(0, '0, '0, 1, 0, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule